// File: doc/BRIEF.md
# Remote terminal command word validator

This block sits behind the word decoders of a dual-redundant serial bus remote terminal. For every decoded word it is told the 16 data bits, the parity bit, whether the sync pattern was the command type, whether Manchester decoding found an error, which bus the word came in on, and whether the word started with no gap after the word before it. It decides whether the word is a new command for this terminal. On acceptance it pulls an active-low strobe low for a fixed time and drives the command word onto a shared output word bus for that whole interval, so that an external lookup can classify the message.

That lookup looks at the subaddress, word count and transmit/receive fields and returns one bit, "illegal". The block samples this bit when the strobe ends, combines it with its own detection of reserved mode codes, and holds the result until the next strobe ends. It also keeps a small sequencing record: which bus owns the command in progress, and a one-cycle abort pulse when a new accepted command replaces it from the other bus. The terminal address pins are sampled only while reset is applied.

The strobe length is set in nanoseconds and derived from the internal clock period, so the same RTL serves any internal clock of 2 MHz or faster.

Top module: `rt_cmd_validator`

## Requirements
- R1: A word is accepted as a command only if `sync_cmd` is 1 and `manch_err` is 0 during its `word_stb` cycle.
- R2: A word is accepted only if `word_data` together with `word_par` holds an odd number of ones.
- R3: A word is accepted only if bits 15..11 equal the captured terminal address or the broadcast value 5'b11111; `bcast` is 1 after an accepted broadcast command and 0 after an accepted addressed one.
- R4: A word with `contig` = 1 is rejected when the previous word on the same bus had no Manchester error and odd parity; after a word that failed either check, a contiguous command is accepted.
- R5: On acceptance `vcmd_n` is 0 for exactly STRB_NS/CLK_NS clock cycles starting with the cycle after `word_stb`; during that time `tbus` carries the accepted word and `tbus_oe` is 1, otherwise `tbus` is 0 and `tbus_oe` is 0.
- R6: `illegal` takes the value of `ext_illegal` from the last low cycle of `vcmd_n` on the clock edge where `vcmd_n` returns to 1, and does not change at any other time.
- R7: A command whose subaddress (bits 9..5) is 0 or 31 and whose mode code (bits 4..0) is 9..15 or 22..31 sets `illegal` regardless of `ext_illegal`; mode codes 0..8 and 16..21 leave it to `ext_illegal`.
- R8: Acceptance sets `seq_busy` to 1 and `seq_bus` to the bus of the command; `seq_done` clears `seq_busy`; an acceptance on a different bus while `seq_busy` is 1 gives `seq_abort` = 1 for one cycle, the cycle in which `vcmd_n` first goes low.
- R9: The terminal address is taken from `rt_addr_pins` while `rst` is 1; later changes on those pins have no effect on which words are accepted.
- R10: While reset is applied and until the first acceptance, `vcmd_n` = 1, `tbus` = 0, `tbus_oe` = 0, `illegal` = 0, `bcast` = 0, `seq_busy` = 0 and `seq_abort` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, period CLK_NS |
| rst | input | 1 | Synchronous reset, active high; address pins sampled while high |
| rt_addr_pins | input | 5 | Terminal address pins |
| word_stb | input | 1 | One-cycle pulse: a decoded word is present |
| word_data | input | 16 | Decoded word, bit 15 sent first |
| word_par | input | 1 | Decoded parity bit |
| sync_cmd | input | 1 | Sync pattern was the command/status type |
| manch_err | input | 1 | Manchester error in data or parity bits |
| bus_sel | input | BUS_W | Bus on which the word arrived |
| contig | input | 1 | Word began with no gap after the previous word on its bus |
| ext_illegal | input | 1 | External lookup result for the word on `tbus` |
| seq_done | input | 1 | Sequencer has finished the current command |
| vcmd_n | output | 1 | Valid-command strobe, active low |
| tbus | output | 16 | Shared word bus carrying the accepted command |
| tbus_oe | output | 1 | `tbus` is being driven |
| illegal | output | 1 | Latched illegal-message flag |
| bcast | output | 1 | Last accepted command was a broadcast |
| seq_busy | output | 1 | A command is being sequenced |
| seq_bus | output | BUS_W | Bus owning the current command |
| seq_abort | output | 1 | One-cycle pulse: command replaced from another bus |

## Verification
The bench builds the block with CLK_NS = 100 and STRB_NS = 500, so the strobe lasts five cycles, long enough to sample the word bus in its middle and to see the flag hold through a second strobe before it changes. Two buses (NUM_BUS = 2) bring the cross-bus abort and the per-bus contiguity record within reach, including a contiguous command on one bus after a faulty word on the same bus. Mode codes on both sides of each reserved range (8, 9, 15, 16, 21, 22, 31) are driven through both mode subaddresses.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;

  localparam logic [4:0] BCAST_ADDR = 5'h1F;

  // Field layout decoded by neighbouring logic: address, T/R, subaddress, count/mode code.
  typedef struct packed {
    logic [4:0] addr;
    logic       tr;
    logic [4:0] sa;
    logic [4:0] cnt;
  } cmd_fields_t;

  function automatic logic parity_is_odd(input logic [15:0] data, input logic par);
    return ^{data, par};
  endfunction

  function automatic logic addr_hit(input logic [4:0] addr, input logic [4:0] own);
    return (addr == own) || (addr == BCAST_ADDR);
  endfunction

  function automatic logic is_mode_sa(input logic [4:0] sa);
    return (sa == 5'd0) || (sa == 5'd31);
  endfunction

  function automatic logic code_reserved(input logic [4:0] code);
    return ((code >= 5'd9) && (code <= 5'd15)) || (code >= 5'd22);
  endfunction

  function automatic logic reserved_mode(input logic [15:0] data);
    cmd_fields_t f;
    f = cmd_fields_t'(data);
    return is_mode_sa(f.sa) && code_reserved(f.cnt);
  endfunction

endpackage

// File: rtl/rt_cmd_check.sv
module rt_cmd_check
  import rt_cmd_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int BUS_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_stb,
  input  logic [15:0]      word_data,
  input  logic             word_par,
  input  logic             sync_cmd,
  input  logic             manch_err,
  input  logic [BUS_W-1:0] bus_sel,
  input  logic             contig,
  input  logic [4:0]       own_addr,
  output logic             accept,
  output logic             is_bcast,
  output logic             is_rsv
);

  logic [NUM_BUS-1:0] prev_good;
  logic               word_good;
  logic               sel_prev_good;
  logic               blocked_contig;
  logic               addr_ok;
  cmd_fields_t        fld;

  assign fld       = cmd_fields_t'(word_data);
  assign word_good = !manch_err && parity_is_odd(word_data, word_par);
  assign addr_ok   = addr_hit(fld.addr, own_addr);

  // Per-bus memory of whether the last word seen there was well formed.
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus_track
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_good[b] <= 1'b0;
      end else if (word_stb && (bus_sel == BUS_W'(b))) begin
        prev_good[b] <= word_good;
      end
    end
  end

  always_comb begin
    sel_prev_good = 1'b0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (bus_sel == BUS_W'(b)) sel_prev_good = prev_good[b];
    end
  end

  assign blocked_contig = contig && sel_prev_good;
  assign accept   = word_stb && sync_cmd && word_good && addr_ok && !blocked_contig;
  assign is_bcast = (fld.addr == BCAST_ADDR);
  assign is_rsv   = reserved_mode(word_data);

  // R4: a contiguous word after a good word on its bus never passes
  assert_contig_reject_R4: assert property (@(posedge clk) disable iff (rst)
    (word_stb && contig && sel_prev_good) |-> !accept);

endmodule

// File: rtl/rt_strobe_gen.sv
module rt_strobe_gen #(
  parameter int STRB_CYCLES = 5,
  parameter int CNT_W       = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [15:0] word_in,
  output logic        strb_n,
  output logic [15:0] bus_out,
  output logic        bus_oe,
  output logic        end_pulse
);

  logic [CNT_W-1:0] cnt;
  logic [15:0]      word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      word_q <= '0;
    end else if (load) begin
      cnt    <= CNT_W'(STRB_CYCLES);
      word_q <= word_in;
    end else if (cnt != '0) begin
      cnt    <= cnt - 1'b1;
    end
  end

  assign bus_oe    = (cnt != '0);
  assign strb_n    = !bus_oe;
  assign bus_out   = bus_oe ? word_q : '0;
  assign end_pulse = (cnt == CNT_W'(1)) && !load;

  // R5: counter never exceeds the strobe length
  always_comb begin
    assert_cnt_range_R5: assert (rst || (cnt <= CNT_W'(STRB_CYCLES)));
  end

  // R5: strobe never shorter than the programmed length once started
  assert_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(strb_n) && STRB_CYCLES > 1) |=> !strb_n);

endmodule

// File: rtl/rt_illegal_latch.sv
module rt_illegal_latch (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic rsv_in,
  input  logic capture,
  input  logic ext_ill,
  output logic illegal
);

  logic rsv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsv_q   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      if (load)    rsv_q   <= rsv_in;
      if (capture) illegal <= ext_ill || rsv_q;
    end
  end

  // R6: flag changes only at a capture point
  assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(illegal));

  // R7: reserved mode code forces the flag
  assert_rsv_forced_R7: assert property (@(posedge clk) disable iff (rst)
    (capture && rsv_q) |=> illegal);

endmodule

// File: rtl/rt_cmd_validator.sv
module rt_cmd_validator
  import rt_cmd_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int CLK_NS  = 100,
  parameter int STRB_NS = 500,
  localparam int BUS_W       = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int STRB_CYCLES = (STRB_NS + CLK_NS - 1) / CLK_NS,
  localparam int CNT_W       = $clog2(STRB_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       rt_addr_pins,
  input  logic             word_stb,
  input  logic [15:0]      word_data,
  input  logic             word_par,
  input  logic             sync_cmd,
  input  logic             manch_err,
  input  logic [BUS_W-1:0] bus_sel,
  input  logic             contig,
  input  logic             ext_illegal,
  input  logic             seq_done,
  output logic             vcmd_n,
  output logic [15:0]      tbus,
  output logic             tbus_oe,
  output logic             illegal,
  output logic             bcast,
  output logic             seq_busy,
  output logic [BUS_W-1:0] seq_bus,
  output logic             seq_abort
);

  logic [4:0] rt_addr_q;
  logic       accept;
  logic       acc_bcast;
  logic       acc_rsv;
  logic       strobe_end;

  // Address captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) rt_addr_q <= rt_addr_pins;
  end

  rt_cmd_check #(
    .NUM_BUS (NUM_BUS),
    .BUS_W   (BUS_W)
  ) u_check (
    .clk       (clk),
    .rst       (rst),
    .word_stb  (word_stb),
    .word_data (word_data),
    .word_par  (word_par),
    .sync_cmd  (sync_cmd),
    .manch_err (manch_err),
    .bus_sel   (bus_sel),
    .contig    (contig),
    .own_addr  (rt_addr_q),
    .accept    (accept),
    .is_bcast  (acc_bcast),
    .is_rsv    (acc_rsv)
  );

  rt_strobe_gen #(
    .STRB_CYCLES (STRB_CYCLES),
    .CNT_W       (CNT_W)
  ) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .word_in   (word_data),
    .strb_n    (vcmd_n),
    .bus_out   (tbus),
    .bus_oe    (tbus_oe),
    .end_pulse (strobe_end)
  );

  rt_illegal_latch u_ill (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .rsv_in  (acc_rsv),
    .capture (strobe_end),
    .ext_ill (ext_illegal),
    .illegal (illegal)
  );

  // Sequencing record: ownership, abort on cross-bus takeover.
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_busy  <= 1'b0;
      seq_bus   <= '0;
      seq_abort <= 1'b0;
      bcast     <= 1'b0;
    end else begin
      seq_abort <= accept && seq_busy && (bus_sel != seq_bus);
      if (accept) begin
        seq_busy <= 1'b1;
        seq_bus  <= bus_sel;
        bcast    <= acc_bcast;
      end else if (seq_done) begin
        seq_busy <= 1'b0;
      end
    end
  end

  // R1: a strobe start follows a clean command-sync word
  assert_sync_clean_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(vcmd_n) |-> $past(word_stb && sync_cmd && !manch_err));

  // R2: a strobe start follows a word of odd parity
  assert_parity_odd_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(vcmd_n) |-> $past(^{word_data, word_par}));

  // R3: strobed word is addressed to this terminal or broadcast
  assert_addr_match_R3: assert property (@(posedge clk) disable iff (rst)
    !vcmd_n |-> ((tbus[15:11] == rt_addr_q) || (tbus[15:11] == BCAST_ADDR)));

  // R5: bus driven exactly while the strobe is low
  assert_bus_drive_R5: assert property (@(posedge clk) disable iff (rst)
    vcmd_n |-> (!tbus_oe && (tbus == 16'h0000)));

  // R8: abort only accompanies a fresh strobe while busy
  assert_abort_ctx_R8: assert property (@(posedge clk) disable iff (rst)
    seq_abort |-> (seq_busy && !vcmd_n));

  // R9: captured address frozen after reset
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(rt_addr_q));

endmodule

// File: tb/rt_cmd_validator_tb.sv
module rt_cmd_validator_tb;

  localparam int CLK_PER = 10;
  localparam int N       = 5; // 500 ns / 100 ns

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rt_addr_pins = 5'd5;
  logic        word_stb = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_par = 1'b0;
  logic        sync_cmd = 1'b0;
  logic        manch_err = 1'b0;
  logic [0:0]  bus_sel = '0;
  logic        contig = 1'b0;
  logic        ext_illegal;
  logic        seq_done = 1'b0;
  logic        vcmd_n;
  logic [15:0] tbus;
  logic        tbus_oe;
  logic        illegal;
  logic        bcast;
  logic        seq_busy;
  logic [0:0]  seq_bus;
  logic        seq_abort;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [4:0] bad_sa = 5'd7;

  // External lookup model: one subaddress flagged illegal.
  assign ext_illegal = tbus_oe && (tbus[9:5] == bad_sa);

  always #(CLK_PER/2) clk = ~clk;

  rt_cmd_validator #(.NUM_BUS(2), .CLK_NS(100), .STRB_NS(500)) u_dut (
    .clk(clk), .rst(rst), .rt_addr_pins(rt_addr_pins), .word_stb(word_stb),
    .word_data(word_data), .word_par(word_par), .sync_cmd(sync_cmd),
    .manch_err(manch_err), .bus_sel(bus_sel), .contig(contig),
    .ext_illegal(ext_illegal), .seq_done(seq_done), .vcmd_n(vcmd_n),
    .tbus(tbus), .tbus_oe(tbus_oe), .illegal(illegal), .bcast(bcast),
    .seq_busy(seq_busy), .seq_bus(seq_bus), .seq_abort(seq_abort)
  );

  function automatic logic [15:0] mk(input logic [4:0] a, input logic tr,
                                     input logic [4:0] sa, input logic [4:0] c);
    return {a, tr, sa, c};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one word; returns at the negedge after the sampling posedge.
  task automatic send(input logic [15:0] d, input logic b, input logic cs,
                      input logic me, input logic badp, input logic ctg);
    @(negedge clk);
    word_data = d;
    word_par  = (~^d) ^ badp;
    bus_sel   = b;
    sync_cmd  = cs;
    manch_err = me;
    contig    = ctg;
    word_stb  = 1'b1;
    @(negedge clk);
    word_stb  = 1'b0;
    contig    = 1'b0;
    manch_err = 1'b0;
  endtask

  task automatic expect_reject(input string tag);
    chk(tag, vcmd_n, 1);
    idle(1);
    chk(tag, vcmd_n, 1);
  endtask

  task automatic finish_seq;
    @(negedge clk); seq_done = 1'b1;
    @(negedge clk); seq_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 vcmd_n", vcmd_n, 1);
    chk("R10 tbus", tbus, 0);
    chk("R10 tbus_oe", tbus_oe, 0);
    chk("R10 illegal", illegal, 0);
    chk("R10 bcast", bcast, 0);
    chk("R10 seq_busy", seq_busy, 0);
    chk("R10 seq_abort", seq_abort, 0);
  endtask

  task automatic t_strobe;
    logic [15:0] w;
    w = mk(5'd5, 1'b1, 5'd3, 5'd4);
    send(w, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k <= N; k++) begin
      chk("R5 strobe low", vcmd_n, 0);
      chk("R5 bus word", tbus, w);
      chk("R5 bus oe", tbus_oe, 1);
      if (k < N) idle(1);
    end
    idle(1);
    chk("R5 strobe released", vcmd_n, 1);
    chk("R5 bus cleared", tbus, 0);
    chk("R8 busy set", seq_busy, 1);
    chk("R8 bus recorded", seq_bus, 0);
    finish_seq();
    chk("R8 busy cleared", seq_busy, 0);
  endtask

  task automatic t_sync_manch;
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_reject("R1 data sync");
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_reject("R1 manchester error");
  endtask

  task automatic t_parity;
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    expect_reject("R2 even parity");
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 odd parity accepted", vcmd_n, 0);
    idle(N);
    finish_seq();
  endtask

  task automatic t_address;
    rt_addr_pins = 5'd9;
    send(mk(5'd9, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_reject("R9 pins after reset ignored");
    send(mk(5'd6, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_reject("R3 other address");
    send(mk(5'd31, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 broadcast accepted", vcmd_n, 0);
    chk("R3 bcast flag", bcast, 1);
    idle(N);
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9 captured address accepted", vcmd_n, 0);
    chk("R3 bcast cleared", bcast, 0);
    idle(N);
    finish_seq();
  endtask

  task automatic t_contig;
    send(16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // good data word on bus 0
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    expect_reject("R4 contiguous after good word");
    send(16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // faulty word on bus 1
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R4 contiguous after faulty word", vcmd_n, 0);
    idle(N);
    finish_seq();
  endtask

  task automatic t_illegal;
    send(mk(5'd5, 1'b0, bad_sa, 5'd2), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(N - 1);
    chk("R6 not yet captured", illegal, 0);
    idle(1);
    chk("R6 captured at strobe end", illegal, 1);
    send(mk(5'd5, 1'b0, 5'd4, 5'd2), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(N - 1);
    chk("R6 held through next strobe", illegal, 1);
    idle(1);
    chk("R6 legal recaptured", illegal, 0);
    finish_seq();
  endtask

  task automatic rsv_case(input logic [4:0] sa, input logic [4:0] code, input int exp);
    send(mk(5'd5, 1'b1, sa, code), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(N);
    chk($sformatf("R7 sa %0d code %0d", sa, code), illegal, exp);
  endtask

  task automatic t_reserved;
    rsv_case(5'd0, 5'd8, 0);
    rsv_case(5'd0, 5'd9, 1);
    rsv_case(5'd31, 5'd15, 1);
    rsv_case(5'd31, 5'd16, 0);
    rsv_case(5'd0, 5'd21, 0);
    rsv_case(5'd31, 5'd22, 1);
    rsv_case(5'd0, 5'd31, 1);
    rsv_case(5'd3, 5'd31, 0);
    finish_seq();
  endtask

  task automatic t_abort;
    send(mk(5'd5, 1'b0, 5'd2, 5'd1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 no abort when idle", seq_abort, 0);
    idle(2);
    send(mk(5'd5, 1'b0, 5'd2, 5'd3), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 abort on other bus", seq_abort, 1);
    chk("R8 ownership moved", seq_bus, 1);
    chk("R5 restarted word", tbus, mk(5'd5, 1'b0, 5'd2, 5'd3));
    idle(1);
    chk("R8 abort one cycle", seq_abort, 0);
    send(mk(5'd5, 1'b0, 5'd2, 5'd4), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 same bus no abort", seq_abort, 0);
    idle(N);
    finish_seq();
    chk("R8 done clears busy", seq_busy, 0);
  endtask

  initial begin
    idle(1);
    t_reset();
    idle(2);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_strobe();
    t_sync_manch();
    t_parity();
    t_address();
    t_contig();
    t_illegal();
    t_reserved();
    t_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule